// File: doc/BRIEF.md
# Sigma-Delta Serial Bit Sampler

This block recovers the one-bit stream of an external sigma-delta modulator that sends its data in a clocked serial format. It runs on a fast system clock and has a data pin, an optional serial clock pin and a modulator clock that it generates itself. Each recovered bit is presented on `smp_bit` with a single-cycle strobe on `smp_valid`. A later decimation stage consumes that stream.

The sampling clock comes from one of four sources. The first is the external clock pin. The second is the block's own modulator clock, used directly. The other two are half-rate phantoms of that modulator clock. These serve a modulator that divides its input clock by two, so that modulator needs no clock pin. The internal sources are only meaningful when the modulator is clocked from `mod_clk`, which keeps clock and data synchronous. The external clock and data pins pass through multi-flop synchronisers before any edge is detected. Internal sampling events are delayed to match the synchroniser on the data pin.

The configuration is changed only while `enable` is low. Raising `enable` restarts the modulator clock and the half-rate phase, so the first sample always falls on a known edge.

Top module: `sd_serial_sampler`

## Requirements
- R1: While `rst_n` is low, `smp_valid`, `smp_bit` and `mod_clk` are all 0.
- R2: While `enable` is high, `mod_clk` starts low and toggles every max(`half_div`,1)+1 system cycles. Its period is therefore never shorter than four system cycles. While `enable` is low it is held at 0.
- R3: With `src_sel`=0 (external pin), exactly one sample is taken for each rising edge of `ext_sck` when `sample_fall`=0, or for each falling edge when `sample_fall`=1. The sampled value is the level of `ext_sdat` at that edge. Each level of `ext_sck` must last at least two system cycles.
- R4: With `src_sel`=1 (direct modulator clock), one sample is taken on each rising edge of `mod_clk` when `sample_fall`=0, or on each falling edge when `sample_fall`=1. The sampled value is `ext_sdat` as it stood at that edge.
- R5: With `src_sel`=2 (half-rate clock that toggles on `mod_clk` rising edges), samples are taken on every second falling edge of `mod_clk`. The first is the falling edge that follows the first rising edge after `enable` rises. `sample_fall` has no effect in this mode.
- R6: With `src_sel`=3 (half-rate clock that toggles on `mod_clk` falling edges), samples are taken on every second rising edge of `mod_clk`. The first is the second rising edge after `enable` rises. `sample_fall` has no effect in this mode.
- R7: `smp_valid` is high for exactly one cycle per sample. The bits come out in edge order, and `smp_bit` carries the value that the requirement for the current mode defines.
- R8: While `enable` is low, edges on `ext_sck` produce no samples. `smp_valid` stays low once `enable` has been low for three cycles. Each rise of `enable` restarts the half-rate phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel run; low clears the clock generator and the phase |
| src_sel | input | 2 | Clock source: 0 pin, 1 modulator clock, 2 half-rate on rise, 3 half-rate on fall |
| sample_fall | input | 1 | Edge choice for sources 0 and 1: 0 rising, 1 falling |
| half_div | input | DIV_W | Modulator clock half period minus one, in system cycles |
| ext_sck | input | 1 | External serial clock pin (asynchronous) |
| ext_sdat | input | 1 | Serial data pin (asynchronous) |
| mod_clk | output | 1 | Generated modulator clock |
| smp_valid | output | 1 | One-cycle strobe per captured bit |
| smp_bit | output | 1 | Captured bit |

## Verification
The bench drives a modulator model for all four sources and both edge choices. It changes data only on edges that do not sample, and it checks both the number of recovered bits and their values against its own model of the qualifying edges. Misaligning the synchroniser delay against the internal events would latch the next bit instead of the current one. Starting the half-rate phase on the wrong edge, or failing to restart it on a new enable, would shift every sample by half a modulator period, which changes both the count and the values. Smallest and zero dividers test the floor on the clock half period. External edges toggled while disabled must yield no bits. Two or more valid cycles in a row would reveal an edge detector that fires on a level instead of a transition.

// File: rtl/sds_pkg.sv
package sds_pkg;
   typedef enum logic [1:0] {
      SRC_EXT_PIN   = 2'd0,
      SRC_MCLK      = 2'd1,
      SRC_HALF_RISE = 2'd2,
      SRC_HALF_FALL = 2'd3
   } sds_src_e;
endpackage

// File: rtl/sds_sync.sv
// Chain of flops used both as a pin synchroniser and as an event delay line.
module sds_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/sds_clkgen.sv
// Modulator clock generator with a floor on the half period.
module sds_clkgen #(
   parameter int DIV_W    = 4,
   parameter int MIN_HALF = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             mclk,
   output logic             rise_p,
   output logic             fall_p
);
   localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF - 1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] limit;

   assign limit = (half_div < FLOOR) ? FLOOR : half_div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         mclk   <= 1'b0;
         rise_p <= 1'b0;
         fall_p <= 1'b0;
      end else if (!run) begin
         cnt    <= '0;
         mclk   <= 1'b0;
         rise_p <= 1'b0;
         fall_p <= 1'b0;
      end else if (cnt >= limit) begin
         cnt    <= '0;
         mclk   <= ~mclk;
         rise_p <= ~mclk;
         fall_p <= mclk;
      end else begin
         cnt    <= cnt + 1'b1;
         rise_p <= 1'b0;
         fall_p <= 1'b0;
      end
   end
endmodule

// File: rtl/sds_qualify.sv
// Decides which modulator clock events are sampling events; tracks half-rate phase.
module sds_qualify
   import sds_pkg::*;
#(
   parameter bit HALF_RATE_EN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  sds_src_e src,
   input  logic     sample_fall,
   input  logic     rise_p,
   input  logic     fall_p,
   output logic     take
);
   logic phase;

   if (HALF_RATE_EN) begin : g_half
      logic flip;
      assign flip = ((src == SRC_HALF_RISE) && rise_p) ||
                    ((src == SRC_HALF_FALL) && fall_p);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    phase <= 1'b0;
         else if (!run) phase <= 1'b0;
         else if (flip) phase <= ~phase;
      end
   end else begin : g_nohalf
      assign phase = 1'b0;
   end

   always_comb begin
      unique case (src)
         SRC_MCLK:      take = sample_fall ? fall_p : rise_p;
         SRC_HALF_RISE: take = fall_p & phase;
         SRC_HALF_FALL: take = rise_p & phase;
         default:       take = 1'b0;
      endcase
   end
endmodule

// File: rtl/sd_serial_sampler.sv
module sd_serial_sampler
   import sds_pkg::*;
#(
   parameter int DIV_W        = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int MIN_HALF     = 2,
   parameter bit HALF_RATE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [1:0]       src_sel,
   input  logic             sample_fall,
   input  logic [DIV_W-1:0] half_div,
   input  logic             ext_sck,
   input  logic             ext_sdat,
   output logic             mod_clk,
   output logic             smp_valid,
   output logic             smp_bit
);
   localparam int EV_DELAY = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_HALF < 2) begin : g_bad_half
      $error("MIN_HALF must be at least 2 to keep the serial clock at or below a quarter of clk");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end

   sds_src_e src_e;
   assign src_e = sds_src_e'(src_sel);

   // Pin synchronisers
   logic [1:0] pins_s;
   logic       sck_s, dat_s, sck_q;

   sds_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_pin_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ext_sck, ext_sdat}),
      .q    (pins_s)
   );
   assign sck_s = pins_s[1];
   assign dat_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   logic ext_take;
   assign ext_take = enable & (sample_fall ? (sck_q & ~sck_s) : (sck_s & ~sck_q));

   // Internal modulator clock and its sampling events
   logic rise_p, fall_p, int_take_raw, int_take;

   sds_clkgen #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (enable),
      .half_div(half_div),
      .mclk    (mod_clk),
      .rise_p  (rise_p),
      .fall_p  (fall_p)
   );

   sds_qualify #(.HALF_RATE_EN(HALF_RATE_EN)) u_qualify (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (enable),
      .src        (src_e),
      .sample_fall(sample_fall),
      .rise_p     (rise_p),
      .fall_p     (fall_p),
      .take       (int_take_raw)
   );

   // Delay internal events to line up with the data synchroniser
   sds_sync #(.STAGES(EV_DELAY), .WIDTH(1)) u_ev_delay (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (int_take_raw),
      .q    (int_take)
   );

   logic take;
   assign take = (src_e == SRC_EXT_PIN) ? ext_take : int_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_bit   <= 1'b0;
      end else begin
         smp_valid <= take;
         if (take) smp_bit <= dat_s;
      end
   end
endmodule

// File: rtl/sds_sampler_chk.sv
module sds_sampler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic [1:0] src_sel,
   input logic       mod_clk,
   input logic       smp_valid
);
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid); // R7

   AST_MCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !mod_clk); // R2

   AST_MCLK_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_clk) |=> (mod_clk || !$past(enable))); // R2

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !$past(enable) && !$past(enable, 2) && !$past(enable, 3)) |-> !smp_valid); // R8

   AST_HALF_RATE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && src_sel[1]) |->
         (!$past(smp_valid) && !$past(smp_valid, 2) && !$past(smp_valid, 3))); // R5
endmodule

bind sd_serial_sampler sds_sampler_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .src_sel  (src_sel),
   .mod_clk  (mod_clk),
   .smp_valid(smp_valid)
);

// File: tb/sd_serial_sampler_tb.sv
`timescale 1ns/1ps
module sd_serial_sampler_tb;
   localparam int DIV_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic [1:0]       src_sel = 2'd0;
   logic             sample_fall = 1'b0;
   logic [DIV_W-1:0] half_div = '0;
   logic             ext_sck = 1'b0;
   logic             ext_sdat = 1'b0;
   logic             mod_clk, smp_valid, smp_bit;

   int  checks = 0;
   int  fails  = 0;
   int  dbl_valid = 0;
   bit  prev_valid = 1'b0;
   bit  done = 1'b0;
   bit  got_q[$];
   bit  exp_q[$];

   always #10 clk = ~clk;

   sd_serial_sampler #(.DIV_W(DIV_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
      .sample_fall(sample_fall), .half_div(half_div), .ext_sck(ext_sck),
      .ext_sdat(ext_sdat), .mod_clk(mod_clk), .smp_valid(smp_valid), .smp_bit(smp_bit)
   );

   always @(negedge clk) begin
      if (rst_n && smp_valid) begin
         got_q.push_back(smp_bit);
         if (prev_valid) dbl_valid++;
      end
      prev_valid = smp_valid;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int half_len(input int div);
      return ((div < 1) ? 1 : div) + 1;
   endfunction

   function automatic string mode_req(input int src);
      case (src)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic run_segment(input int src, input bit pol, input int div, input int ncyc);
      bit ph, last_m, is_edge, rising, qual, first;
      int hc, run_len, bad_half, mism;
      @(negedge clk);
      enable = 1'b0;
      src_sel = 2'(src);
      sample_fall = pol;
      half_div = DIV_W'(div);
      ext_sck = 1'b0;
      repeat (4) @(negedge clk);
      got_q.delete();
      exp_q.delete();
      ph = 1'b0; last_m = 1'b0; first = 1'b1;
      run_len = 0; bad_half = 0;
      hc = 2 + int'($urandom % 4);
      enable = 1'b1;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         is_edge = 1'b0; rising = 1'b0; qual = 1'b0;
         if (src == 0) begin
            hc--;
            if (hc == 0) begin
               ext_sck = ~ext_sck;
               is_edge = 1'b1;
               rising = ext_sck;
               hc = 2 + int'($urandom % 4);
            end
         end else begin
            run_len++;
            if (mod_clk != last_m) begin
               is_edge = 1'b1;
               rising = mod_clk;
               last_m = mod_clk;
               if (!first && run_len != half_len(div)) bad_half++;
               first = 1'b0;
               run_len = 0;
            end
         end
         if (is_edge) begin
            case (src)
               0, 1: qual = pol ? !rising : rising;
               2: if (rising) ph = ~ph; else qual = ph;
               default: if (!rising) ph = ~ph; else qual = ph;
            endcase
            if (qual) exp_q.push_back(ext_sdat);
            else      ext_sdat = 1'($urandom % 2);
         end
      end
      if (src == 0) repeat (6) @(negedge clk);
      enable = 1'b0;
      repeat (8) @(negedge clk);
      check(got_q.size() == exp_q.size(), mode_req(src), "sample count",
            got_q.size(), exp_q.size());
      mism = 0;
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         if (got_q[i] != exp_q[i]) mism++;
      check(mism == 0, "R7", "bit mismatches", mism, 0);
      if (src != 0) check(bad_half == 0, "R2", "mod_clk half-period errors", bad_half, 0);
   endtask

   initial begin
      int mclk_hi;
      void'($urandom(32'd4077));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(smp_valid == 1'b0, "R1", "smp_valid in reset", smp_valid, 0);
      check(smp_bit == 1'b0, "R1", "smp_bit in reset", smp_bit, 0);
      check(mod_clk == 1'b0, "R1", "mod_clk in reset", mod_clk, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R8: pin edges while disabled are ignored, mod_clk held low
      got_q.delete();
      mclk_hi = 0;
      for (int k = 0; k < 12; k++) begin
         ext_sck = ~ext_sck;
         ext_sdat = ~ext_sdat;
         repeat (3) begin
            @(negedge clk);
            if (mod_clk) mclk_hi++;
         end
      end
      repeat (6) @(negedge clk);
      check(got_q.size() == 0, "R8", "samples while disabled", got_q.size(), 0);
      check(mclk_hi == 0, "R2", "mod_clk high cycles while disabled", mclk_hi, 0);

      // Directed corner cases
      run_segment(0, 1'b0, 3, 300);   // R3 rising
      run_segment(0, 1'b1, 3, 300);   // R3 falling
      run_segment(1, 1'b0, 1, 300);   // R4 minimum divider
      run_segment(1, 1'b1, 0, 300);   // R4, R2 zero divider clamped
      run_segment(2, 1'b0, 1, 300);   // R5
      run_segment(2, 1'b1, 2, 301);   // R5 polarity ignored, R8 phase restart
      run_segment(3, 1'b0, 1, 300);   // R6
      run_segment(3, 1'b1, 3, 303);   // R6 polarity ignored, R8 phase restart

      // Constrained random segments
      for (int s = 0; s < 10; s++)
         run_segment(int'($urandom % 4), 1'($urandom % 2), int'($urandom % 7),
                     200 + int'($urandom % 150));

      check(dbl_valid == 0, "R7", "back-to-back valid cycles", dbl_valid, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule